// File: doc/BRIEF.md
# ALU Status Flag Generator

This block sits beside the adder and logic unit of a 32-bit integer ALU and works out the six status flags for each operation: carry, overflow, sign, zero, auxiliary carry and parity. It sees the two operands, the carry-in and the operation class (add, subtract or logic) on one side, and the finished result on the other. It does not compute the result itself. The flag values it gives back are combinational.

A size input narrows every flag to an 8-, 16- or 32-bit view of the operands and the result. Bits above the chosen size are ignored. The block also holds a flags register. That register loads the freshly computed flags on a clock edge only when the flag write-enable is high, so an instruction that does not write the flags leaves the last stored value in place.

Top module: `alu_flag_unit`

## Requirements
- R1: `flags_now[0]` (carry) is the carry out of the top bit of the chosen size on add (`op_sel`=00, a+b+carry_in). On subtract (`op_sel`=01, a-b-carry_in) it is the unsigned borrow.
- R2: `flags_now[5]` (overflow) is set on add when both operands have the same sign and the result sign differs from it. It is set on subtract when the operand signs differ and the result sign differs from the first operand's sign. Signs are the top bit at the chosen size.
- R3: `flags_now[4]` (sign) equals the top bit of the result at the chosen size.
- R4: `flags_now[3]` (zero) is set when every result bit within the chosen size is 0.
- R5: `flags_now[2]` (auxiliary carry) is the carry (on add) or the borrow (on subtract) out of bit 3 into bit 4, with carry_in included.
- R6: `flags_now[1]` (parity) is set when the low 8 result bits hold an even number of ones, whatever the chosen size.
- R7: For a logic operation (`op_sel`=10 or 11), carry, overflow and auxiliary carry are 0 and carry_in has no effect.
- R8: `width_sel` 00 selects 8 bits, 01 selects 16 bits, and 10 or 11 selects 32 bits. Operand and result bits above the chosen size have no effect on any flag.
- R9: `flags_q` takes the value of `flags_now` on a rising clock edge when `flag_we` is 1, and holds its value when `flag_we` is 0.
- R10: `flags_q` becomes all zeros on a rising edge with `rst_n` low, whatever `flag_we` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the flags register |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry (add) or borrow (subtract) into bit 0 |
| op_sel | input | 2 | 00 add, 01 subtract, 10/11 logic |
| width_sel | input | 2 | 00 8-bit, 01 16-bit, 10/11 32-bit |
| result | input | 32 | Result produced by the ALU datapath |
| flag_we | input | 1 | Load enable for the flags register |
| flags_now | output | 6 | Combinational flags: [0] C, [1] P, [2] AC, [3] Z, [4] S, [5] O |
| flags_q | output | 6 | Registered flags, same bit layout |

## Verification
The bench builds the block with its default data width of 32, so the 8-, 16- and 32-bit views all come from a single elaboration. With that width the carry, sign and overflow positions can be driven at bits 7/8, 15/16 and 31/32 within one run. Operands with junk above the chosen size show that the narrow views mask correctly. A 32-bit result whose low byte and full word have different parity shows that parity looks at the low byte only.

// File: rtl/alu_flag_pkg.sv
// Package: shared encodings for the ALU status flag generator.
// Assumes: flag bit positions are fixed and decoded by consumers of the word.
package alu_flag_pkg;
    localparam int FLAG_W = 6;
    localparam int FLG_C  = 0;
    localparam int FLG_P  = 1;
    localparam int FLG_AC = 2;
    localparam int FLG_Z  = 3;
    localparam int FLG_S  = 4;
    localparam int FLG_O  = 5;
    localparam int PAR_W  = 8;
    localparam int NIB_W  = 4;
    localparam int NUM_SZ = 3;

    typedef enum logic [1:0] {
        OP_ADD       = 2'b00,
        OP_SUB       = 2'b01,
        OP_LOGIC     = 2'b10,
        OP_LOGIC_ALT = 2'b11
    } op_sel_e;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } size_e;
endpackage

// File: rtl/flag_width_view.sv
// Module: flag_width_view
// Masks a value down to the chosen operand size and reports its top bit.
// Assumes: DATA_W is divisible by 4; the sizes are DATA_W/4, DATA_W/2, DATA_W.
module flag_width_view #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        width_sel,
    input  logic [DATA_W-1:0] value_in,
    output logic [DATA_W-1:0] value_msk,
    output logic              top_bit
);
    import alu_flag_pkg::*;

    logic [NUM_SZ-1:0][DATA_W-1:0] masks;
    logic [NUM_SZ-1:0]             tops;
    logic [1:0]                    idx;

    for (genvar g = 0; g < NUM_SZ; g++) begin : g_size
        localparam int W = DATA_W >> (NUM_SZ - 1 - g);
        assign masks[g] = {DATA_W{1'b1}} >> (DATA_W - W);
        assign tops[g]  = value_in[W-1];
    end

    // Fold the two 32-bit encodings onto one size slot.
    always_comb begin
        idx = (width_sel == SZ_WORD_ALT) ? 2'(SZ_WORD) : width_sel;
    end

    // Select the masked value and top bit for the chosen size.
    always_comb begin
        value_msk = value_in & masks[idx];
        top_bit   = tops[idx];
    end
endmodule

// File: rtl/flag_arith.sv
// Module: flag_arith
// Derives carry, auxiliary carry and overflow from the operands, carry-in and
// result sign. Assumes operands are already masked to the chosen size.
module flag_arith #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        op_sel,
    input  logic [1:0]        width_sel,
    input  logic [DATA_W-1:0] a_msk,
    input  logic [DATA_W-1:0] b_msk,
    input  logic              a_top,
    input  logic              b_top,
    input  logic              r_top,
    input  logic              carry_in,
    output logic              carry,
    output logic              aux,
    output logic              ovf
);
    import alu_flag_pkg::*;

    localparam int BYTE_W = DATA_W / 4;
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] ext;
    logic [NIB_W:0]  nib;
    logic [DATA_W:0] cin_ext;
    logic [NIB_W:0]  cin_nib;
    logic            ext_carry;

    assign cin_ext = {{DATA_W{1'b0}}, carry_in};
    assign cin_nib = {{NIB_W{1'b0}}, carry_in};

    // Widened add or subtract so the bit above each size holds carry/borrow.
    always_comb begin
        if (op_sel == OP_SUB) begin
            ext = {1'b0, a_msk} - {1'b0, b_msk} - cin_ext;
            nib = {1'b0, a_msk[NIB_W-1:0]} - {1'b0, b_msk[NIB_W-1:0]} - cin_nib;
        end else begin
            ext = {1'b0, a_msk} + {1'b0, b_msk} + cin_ext;
            nib = {1'b0, a_msk[NIB_W-1:0]} + {1'b0, b_msk[NIB_W-1:0]} + cin_nib;
        end
    end

    // Pick the carry bit just above the chosen size.
    always_comb begin
        case (width_sel)
            SZ_BYTE: ext_carry = ext[BYTE_W];
            SZ_HALF: ext_carry = ext[HALF_W];
            default: ext_carry = ext[DATA_W];
        endcase
    end

    // Gate by operation class; logic operations clear all three.
    always_comb begin
        carry = 1'b0;
        aux   = 1'b0;
        ovf   = 1'b0;
        case (op_sel)
            OP_ADD: begin
                carry = ext_carry;
                aux   = nib[NIB_W];
                ovf   = (a_top == b_top) && (r_top != a_top);
            end
            OP_SUB: begin
                carry = ext_carry;
                aux   = nib[NIB_W];
                ovf   = (a_top != b_top) && (r_top != a_top);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flag_result.sv
// Module: flag_result
// Derives sign, zero and parity from the masked result.
// Assumes: the result is already masked; parity covers the low byte only.
module flag_result #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] r_msk,
    input  logic              r_top,
    output logic              sign,
    output logic              zero,
    output logic              parity
);
    import alu_flag_pkg::*;

    // Result-only flags.
    always_comb begin
        sign   = r_top;
        zero   = (r_msk == '0);
        parity = ~^r_msk[PAR_W-1:0];
    end
endmodule

// File: rtl/flag_reg.sv
// Module: flag_reg
// Holds the architectural flags word; loads only on write-enable.
// Assumes: synchronous active-low reset that takes priority over the load.
module flag_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Reset, load or hold the stored flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end
endmodule

// File: rtl/alu_flag_unit.sv
// Module: alu_flag_unit (top)
// Produces six status flags for an ALU operation at 8/16/32-bit size and keeps
// a write-enabled flags register. Assumes the result input is the datapath's
// output for the same operands and operation.
module alu_flag_unit #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              carry_in,
    input  logic [1:0]        op_sel,
    input  logic [1:0]        width_sel,
    input  logic [DATA_W-1:0] result,
    input  logic              flag_we,
    output logic [5:0]        flags_now,
    output logic [5:0]        flags_q
);
    import alu_flag_pkg::*;

    localparam int NUM_VIEW = 3;

    logic [NUM_VIEW-1:0][DATA_W-1:0] raw_v;
    logic [NUM_VIEW-1:0][DATA_W-1:0] msk_v;
    logic [NUM_VIEW-1:0]             top_v;
    logic c_f, ac_f, o_f, s_f, z_f, p_f;

    assign raw_v[0] = op_a;
    assign raw_v[1] = op_b;
    assign raw_v[2] = result;

    for (genvar v = 0; v < NUM_VIEW; v++) begin : g_view
        flag_width_view #(.DATA_W(DATA_W)) u_view (
            .width_sel (width_sel),
            .value_in  (raw_v[v]),
            .value_msk (msk_v[v]),
            .top_bit   (top_v[v])
        );
    end

    flag_arith #(.DATA_W(DATA_W)) u_arith (
        .op_sel    (op_sel),
        .width_sel (width_sel),
        .a_msk     (msk_v[0]),
        .b_msk     (msk_v[1]),
        .a_top     (top_v[0]),
        .b_top     (top_v[1]),
        .r_top     (top_v[2]),
        .carry_in  (carry_in),
        .carry     (c_f),
        .aux       (ac_f),
        .ovf       (o_f)
    );

    flag_result #(.DATA_W(DATA_W)) u_res (
        .r_msk  (msk_v[2]),
        .r_top  (top_v[2]),
        .sign   (s_f),
        .zero   (z_f),
        .parity (p_f)
    );

    // Assemble the flags word in its fixed bit layout.
    always_comb begin
        flags_now         = '0;
        flags_now[FLG_C]  = c_f;
        flags_now[FLG_P]  = p_f;
        flags_now[FLG_AC] = ac_f;
        flags_now[FLG_Z]  = z_f;
        flags_now[FLG_S]  = s_f;
        flags_now[FLG_O]  = o_f;
    end

    flag_reg #(.W(FLAG_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flag_we),
        .d     (flags_now),
        .q     (flags_q)
    );
endmodule

// File: rtl/alu_flag_unit_checker.sv
// Module: alu_flag_unit_checker
// Property checks on the flag generator's ports, bound to every instance.
module alu_flag_unit_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              carry_in,
    input logic [1:0]        op_sel,
    input logic [1:0]        width_sel,
    input logic [DATA_W-1:0] result,
    input logic              flag_we,
    input logic [5:0]        flags_now,
    input logic [5:0]        flags_q
);
    logic a_sgn, b_sgn;

    // Operand signs at the chosen size, for the overflow property.
    always_comb begin
        case (width_sel)
            2'b00:   begin a_sgn = op_a[DATA_W/4-1]; b_sgn = op_b[DATA_W/4-1]; end
            2'b01:   begin a_sgn = op_a[DATA_W/2-1]; b_sgn = op_b[DATA_W/2-1]; end
            default: begin a_sgn = op_a[DATA_W-1];   b_sgn = op_b[DATA_W-1];   end
        endcase
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b00 && a_sgn != b_sgn) |-> !flags_now[5]);

    assert_zero_not_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flags_now[3] |-> (!flags_now[4] && flags_now[1]));

    assert_logic_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel[1] |-> (!flags_now[0] && !flags_now[2] && !flags_now[5]));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags_q));

    assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flags_q == $past(flags_now)));

    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (flags_q == 6'd0));
endmodule

bind alu_flag_unit alu_flag_unit_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/alu_flag_unit_bench.sv
// Directed bench for alu_flag_unit: one task per scenario.
module alu_flag_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] op_a, op_b, result;
    logic        carry_in, flag_we;
    logic [1:0]  op_sel, width_sel;
    logic [5:0]  flags_now, flags_q;
    int          n_chk = 0;
    int          n_err = 0;

    always #4 clk = ~clk;

    alu_flag_unit u_alu_flag_unit (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .op_sel(op_sel), .width_sel(width_sel),
        .result(result), .flag_we(flag_we),
        .flags_now(flags_now), .flags_q(flags_q)
    );

    task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic ci, input logic [31:0] r);
        @(negedge clk);
        op_sel = op; width_sel = sz; op_a = a; op_b = b; carry_in = ci; result = r;
        #1;
    endtask

    // R10: reset clears the register
    task automatic t_reset;
        rst_n = 1'b0; flag_we = 1'b1;
        drive(2'b00, 2'b00, 32'hFF, 32'h1, 1'b0, 32'h0);
        @(posedge clk); @(posedge clk); #1;
        chk("R10 reset value", flags_q, 6'h00);
        @(negedge clk); rst_n = 1'b1; flag_we = 1'b0;
    endtask

    // R1 R5 R6 R4 R2 R3: byte add/sub corners
    task automatic t_byte_arith;
        drive(2'b00, 2'b00, 32'hFF, 32'h01, 1'b0, 32'h00);
        chk("R1 R5 R4 R6 byte add wrap", flags_now, 6'h0F);
        drive(2'b00, 2'b00, 32'h7F, 32'h01, 1'b0, 32'h80);
        chk("R2 R3 byte add overflow", flags_now, 6'h34);
        drive(2'b01, 2'b00, 32'h00, 32'h01, 1'b0, 32'hFF);
        chk("R1 R5 byte sub borrow", flags_now, 6'h17);
        drive(2'b01, 2'b00, 32'h80, 32'h01, 1'b0, 32'h7F);
        chk("R2 byte sub overflow", flags_now, 6'h24);
    endtask

    // R1 R2 R8: half-word carry and overflow
    task automatic t_half;
        drive(2'b00, 2'b01, 32'h0000_8000, 32'h0000_8000, 1'b0, 32'h0001_0000);
        chk("R1 R2 R8 half add", flags_now, 6'h2B);
        drive(2'b10, 2'b01, 32'h0, 32'h0, 1'b0, 32'h0000_8001);
        chk("R3 half sign", flags_now, 6'h10);
        drive(2'b10, 2'b00, 32'h0, 32'h0, 1'b0, 32'h0000_8001);
        chk("R3 R8 byte sign", flags_now, 6'h00);
    endtask

    // R8: junk above the chosen size
    task automatic t_upper_ignored;
        drive(2'b00, 2'b00, 32'hABCD_1203, 32'h5555_0004, 1'b0, 32'hFFFF_FF07);
        chk("R8 upper bits ignored", flags_now, 6'h00);
        drive(2'b10, 2'b00, 32'hFFFF_FFFF, 32'h1, 1'b0, 32'h1234_5600);
        chk("R8 R4 zero at byte", flags_now, 6'h0A);
    endtask

    // R1 R5: carry_in at word size
    task automatic t_word_cin;
        drive(2'b00, 2'b10, 32'hFFFF_FFFF, 32'h0, 1'b1, 32'h0);
        chk("R1 R5 word add cin", flags_now, 6'h0F);
        drive(2'b01, 2'b11, 32'h5, 32'h5, 1'b1, 32'hFFFF_FFFF);
        chk("R1 R5 R8 word sub cin", flags_now, 6'h17);
        drive(2'b01, 2'b10, 32'h8000_0000, 32'h1, 1'b0, 32'h7FFF_FFFF);
        chk("R2 word sub overflow", flags_now, 6'h26);
    endtask

    // R7 R6: logic class and low-byte parity
    task automatic t_logic;
        drive(2'b10, 2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'h8000_0000);
        chk("R7 logic clears", flags_now, 6'h12);
        drive(2'b11, 2'b10, 32'h0, 32'h0, 1'b1, 32'h0000_0103);
        chk("R6 R7 low-byte parity", flags_now, 6'h02);
    endtask

    // R9 R10: write-enable and reset priority
    task automatic t_register;
        drive(2'b00, 2'b00, 32'hFF, 32'h01, 1'b0, 32'h00);
        flag_we = 1'b1;
        @(posedge clk); #1;
        chk("R9 load", flags_q, 6'h0F);
        drive(2'b00, 2'b00, 32'h7F, 32'h01, 1'b0, 32'h80);
        flag_we = 1'b0;
        @(posedge clk); #1;
        chk("R9 hold", flags_q, 6'h0F);
        @(negedge clk); flag_we = 1'b1;
        @(posedge clk); #1;
        chk("R9 reload", flags_q, 6'h34);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R10 reset beats load", flags_q, 6'h00);
        @(negedge clk); rst_n = 1'b1; flag_we = 1'b0;
    endtask

    initial begin
        t_reset;
        t_byte_arith;
        t_half;
        t_upper_ignored;
        t_word_cin;
        t_logic;
        t_register;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule